// File: doc/BRIEF.md
# Serial Attenuator Control Latch

This block is the device-side control logic for a digital step attenuator that is set through a three-wire serial port. The port has a serial clock, a serial data line and a latch-enable line. An 8-bit control word is shifted in, least-significant bit first, on rising edges of the serial clock. A rising edge of latch enable copies the whole word into a holding register. The attenuator stages are driven from that holding register.

The held word is decoded into per-stage enables and into an unsigned attenuation code in half-dB units. A mode input selects the resolution:

- In 1 dB mode the half-dB bit is forced off.
- In half-dB mode the half-dB bit is used, and six bits set the attenuation.

The two end bits of the word carry no meaning.

The three serial lines are asynchronous to the block clock. They pass through a synchronizer, and their edges are detected in the block clock domain. The serial clock therefore has to run well below the block clock.

Top module: `ser_att_ctrl`

## Requirements
- R1: A serial data bit is taken on each rising edge of the serial clock. The first bit shifted in is word bit 0 and the eighth is word bit 7.
- R2: While latch enable is high, rising edges of the serial clock shift nothing. A later latch then shows the word from before those edges.
- R3: After reset, the held word is 0x7C. This gives `att_code` = 62 (31 dB) and `step_en` = 6'b111110 in both modes.
- R4: Word bits 2, 3, 4, 5 and 6 weigh 1, 2, 4, 8 and 16 dB. `att_code` is the attenuation in half-dB units, and a word with none of these bits set gives 0.
- R5: Bit 1 weighs 0.5 dB. When `half_mode` is 1 it adds 1 to `att_code` and sets `step_en[0]`. When `half_mode` is 0 it is treated as zero, so `att_code` is even.
- R6: Word bits 0 and 7 have no effect on `att_code` or `step_en`.
- R7: The outputs change only on a rising edge of latch enable, which copies the whole shift register. The shift register is not cleared, so a short burst of N bits moves the earlier contents down by N places.
- R8: `step_en[i]` drives the stage of weight 2^i half-dB, for i = 0 to 5. Index 0 is the half-dB stage and index 5 is the 16 dB stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Latch enable, asynchronous |
| half_mode | input | 1 | 1 selects half-dB resolution, 0 selects 1 dB |
| step_en | output | 6 | Per-stage enables, index 0 = 0.5 dB through index 5 = 16 dB |
| att_code | output | 6 | Attenuation in half-dB units, 0 to 63 |

## Verification
The hardest case to reach is the blocking of the serial clock while latch enable is high, because the outputs cannot change while latch enable stays high. The stimulus first loads a known word. It then clocks in opposite data with latch enable held high, drops latch enable, and latches again without any clock edges. If the output still shows the first word, the shift register was untouched. A second hard case is the fact that the shift register is not cleared. A four-bit burst is latched, and the result must combine the new nibble with the old upper nibble shifted down.

// File: rtl/ser_att_pkg.sv
// Shared constants for the serial attenuator control latch.
// Assumes an 8-bit control word whose attenuation field sits in bits 1..6.
package ser_att_pkg;
    localparam int WORD_W  = 8;
    localparam int STEP_LO = 1;
    localparam int STEP_N  = 6;
    localparam logic [WORD_W-1:0] RESET_WORD = 8'h7C;
endpackage

// File: rtl/ser_att_sync.sv
// Multi-stage synchronizer with rising-edge detect for N_SIG lines.
// Assumes the inputs change slowly compared with clk.
module ser_att_sync #(
    parameter int N_SIG  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] async_in,
    output logic [N_SIG-1:0] lvl,
    output logic [N_SIG-1:0] rise
);
    logic [N_SIG-1:0] stg_q [STAGES];
    logic [N_SIG-1:0] prev_q;

    // Move each line through the stage chain and keep the last value for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stg_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
            prev_q <= stg_q[STAGES-1];
        end
    end

    // Expose the synchronized level and its rising edge.
    always_comb begin
        lvl  = stg_q[STAGES-1];
        rise = stg_q[STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/ser_att_shift.sv
// LSB-first serial shift register, shifting on serial clock rises while latch enable is low.
// Assumes synchronized inputs. Reset loads the maximum-attenuation word.
module ser_att_shift
    import ser_att_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              le_lvl,
    input  logic              bit_in,
    output logic [WORD_W-1:0] sr_q
);
    logic shift_en;

    // A clock edge is honoured only while latch enable is low.
    always_comb shift_en = sclk_rise & ~le_lvl;

    // New bits enter at the top so the first bit reaches bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= RESET_WORD;
        else if (shift_en) sr_q <= {bit_in, sr_q[WORD_W-1:1]};
    end

    // R2: latch enable high freezes the shift register.
    a_r2_le_blocks_shift: assert property (@(posedge clk) disable iff (!rst_n)
        le_lvl |=> $stable(sr_q));
endmodule

// File: rtl/ser_att_latch.sv
// Holding register that takes the whole shift register on a latch-enable rise.
// Assumes load is a one-cycle pulse.
module ser_att_latch
    import ser_att_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] hold_q
);
    // Reset to maximum attenuation, otherwise copy the word on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= RESET_WORD;
        else if (load) hold_q <= din;
    end

    // R3: reset leaves the maximum-attenuation word.
    a_r3_reset_word: assert property (@(posedge clk)
        !rst_n |=> (hold_q == RESET_WORD));
    // R7: a load copies the full word.
    a_r7_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (hold_q == $past(din)));
    // R7: without a load the held word does not move.
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(hold_q));
endmodule

// File: rtl/ser_att_decode.sv
// Decodes a held word into per-stage enables and a half-dB attenuation code.
// Assumes bit 1 is the half-dB stage, used only when half_mode is 1.
module ser_att_decode
    import ser_att_pkg::*;
(
    input  logic              half_mode,
    input  logic [WORD_W-1:0] word,
    output logic [STEP_N-1:0] step_en,
    output logic [STEP_N-1:0] code
);
    // One enable per stage; the half-dB stage is gated by the mode.
    for (genvar i = 0; i < STEP_N; i++) begin : g_step
        if (i == 0) begin : g_half
            assign step_en[i] = word[STEP_LO+i] & half_mode;
        end else begin : g_full
            assign step_en[i] = word[STEP_LO+i];
        end
    end

    // Add the weight 2^i half-dB of each enabled stage.
    always_comb begin
        code = '0;
        for (int i = 0; i < STEP_N; i++)
            if (step_en[i]) code = code + STEP_N'(1 << i);
    end
endmodule

// File: rtl/ser_att_ctrl.sv
// Top level of the three-wire attenuator control port: synchronizer, shift register,
// latch and decoder. Assumes the serial clock runs well below clk.
module ser_att_ctrl
    import ser_att_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    input  logic              half_mode,
    output logic [STEP_N-1:0] step_en,
    output logic [STEP_N-1:0] att_code
);
    localparam int N_SIG = 3;

    logic [N_SIG-1:0]  s_lvl, s_rise;
    logic [WORD_W-1:0] sr_w, hold_w;

    ser_att_sync #(.N_SIG(N_SIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({ser_le, ser_dat, ser_clk}),
        .lvl(s_lvl), .rise(s_rise)
    );

    ser_att_shift u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(s_rise[0]), .le_lvl(s_lvl[2]), .bit_in(s_lvl[1]),
        .sr_q(sr_w)
    );

    ser_att_latch u_latch (
        .clk(clk), .rst_n(rst_n),
        .load(s_rise[2]), .din(sr_w), .hold_q(hold_w)
    );

    ser_att_decode u_dec (
        .half_mode(half_mode), .word(hold_w),
        .step_en(step_en), .code(att_code)
    );

    // R5: in 1 dB mode the code is always even.
    a_r5_full_mode_even: assert property (@(posedge clk) disable iff (!rst_n)
        !half_mode |-> !att_code[0]);
endmodule

// File: tb/sim_ser_att_ctrl.sv
module sim_ser_att_ctrl;
    localparam int PERIOD = 10;
    localparam int HALF_SER = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, half_mode = 1'b0;
    logic [5:0] step_en, att_code;
    int total = 0, bad = 0;

    ser_att_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .half_mode(half_mode), .step_en(step_en), .att_code(att_code)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic shift_bits(input logic [7:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            ser_dat = w[i];
            wait_clk(HALF_SER);
            ser_clk = 1'b1;
            wait_clk(HALF_SER);
            ser_clk = 1'b0;
        end
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_clk(8);
        ser_le = 1'b0;
        wait_clk(8);
    endtask

    task automatic load_word(input logic [7:0] w);
        shift_bits(w, 8);
        pulse_le();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        half_mode = 1'b0;
        check("R3 code 1dB", att_code, 6'd62);
        check("R3 step_en", step_en, 6'b111110);
        half_mode = 1'b1;
        wait_clk(1);
        check("R3 code half", att_code, 6'd62);
        half_mode = 1'b0;
    endtask

    task automatic t_weights();
        load_word(8'h58);
        check("R4 22dB word", att_code, 6'd44);
        check("R8 22dB stages", step_en, 6'b101100);
        load_word(8'h00);
        check("R4 zero word", att_code, 6'd0);
        for (int b = 2; b <= 6; b++) begin
            load_word(8'(1 << b));
            check("R4 single weight", att_code, 6'(1 << (b - 1)));
        end
    endtask

    task automatic t_half();
        load_word(8'h7E);
        half_mode = 1'b0;
        wait_clk(1);
        check("R5 1dB mode masks bit1", att_code, 6'd62);
        half_mode = 1'b1;
        wait_clk(1);
        check("R5 half mode max", att_code, 6'd63);
        check("R8 half stage enable", step_en, 6'b111111);
        load_word(8'h02);
        check("R5 half step only", att_code, 6'd1);
        half_mode = 1'b0;
        wait_clk(1);
        check("R5 half step dropped", att_code, 6'd0);
    endtask

    task automatic t_ends();
        load_word(8'h81);
        check("R6 end bits only", att_code, 6'd0);
        load_word(8'hD9);
        check("R6 end bits with 22dB", att_code, 6'd44);
    endtask

    task automatic t_le_gate();
        load_word(8'h58);
        ser_le = 1'b1;
        wait_clk(8);
        shift_bits(8'hFF, 8);
        check("R2 output during gated clocks", att_code, 6'd44);
        ser_le = 1'b0;
        wait_clk(8);
        pulse_le();
        check("R2 shift register untouched", att_code, 6'd44);
    endtask

    task automatic t_order_noclear();
        load_word(8'h08);
        check("R1 lsb first bit3", att_code, 6'd4);
        shift_bits(8'h04, 8);
        check("R7 no update before latch", att_code, 6'd4);
        pulse_le();
        check("R1 lsb first bit2", att_code, 6'd2);
        shift_bits(8'h0F, 4);
        pulse_le();
        check("R7 partial burst keeps old bits", att_code, 6'd56);
    endtask

    initial begin
        wait_clk(2);
        t_reset();
        t_weights();
        t_half();
        t_ends();
        t_le_gate();
        t_order_noclear();
        t_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule